// File: doc/BRIEF.md
# Interrupt Request Capture Register

This block captures interrupt requests from the eight input pins of one interrupt controller. Each pin is sampled on every clock edge. A per-pin trigger-select register decides how the pin is captured. A level pin's request bit tracks the pin directly. An edge pin's request bit is set by a low-to-high transition and stays set until it is acknowledged. The block keeps a memory of the last sampled level of each pin, and edge detection compares against that memory.

Each time a pin's sampled level differs from its remembered level, the block reports an event for that pin, one cycle wide. The event carries a status code. The code tells the surrounding logic whether the pin was masked, whether the change merged with a request that was already pending, or whether it is a new request.

The acknowledge port clears the request of an edge pin. A synchronous init input wipes the request bits and the level memory, so that pins already held high are seen again as fresh edges. Priority resolution, in-service tracking and bus access all live outside this block.

Top module: `irq_capture_reg`

## Requirements
- R1: For a pin whose trigger-select bit is 1 (level mode), the request bit one cycle after a sample equals the sampled pin level. An acknowledge of that pin has no effect on its request bit.
- R2: For a pin whose trigger-select bit is 0 (edge mode), the request bit is set when the pin is sampled high and the remembered level is low. Holding the pin high sets nothing more.
- R3: For an edge-mode pin, sampling the pin low only updates the remembered level. The request bit keeps its value.
- R4: An event on a pin reports a 2-bit code in `evt_code[2i+1:2i]`. The code is 2'b01 (masked) if that pin's mask bit is 1. Otherwise it is 2'b10 (coalesced) if the pin is sampled high while its request bit was already 1. Otherwise it is 2'b11 (new). Code 2'b00 appears exactly when no event is reported. The mask affects only the code; requests are still captured.
- R5: An acknowledge (`ack_vld` with pin index `ack_idx`) clears the request bit of that pin in the next cycle if the pin is in edge mode. Other pins are untouched.
- R6: If an acknowledge and a new rising edge hit the same edge-mode pin in the same cycle, the request bit stays set.
- R7: A trigger-select write stores `sel_wdata & SEL_MASK`. Bits outside `SEL_MASK` (default 8'hF8) always stay 0, so those pins are edge mode. The new selection governs samples from the next cycle on. After reset every select bit is 0.
- R8: When `init_clr` is high, the next cycle shows all request bits at 0 and no events. The level memory is cleared, so a pin still high in the following sample is captured as a new edge. The trigger-select register is kept.
- R9: `evt_vld[i]` is high for exactly one cycle, in the cycle after a sample whose level differs from the remembered level of pin i, and is low otherwise.
- R10: After reset, the request vector, the events and all codes are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_lvl | input | NUM_PINS | Interrupt input levels, sampled every edge |
| pin_mask | input | NUM_PINS | Per-pin mask value, used for the status code |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Index of the pin being acknowledged |
| sel_we | input | 1 | Trigger-select write enable |
| sel_wdata | input | NUM_PINS | Trigger-select write data (1 = level mode) |
| init_clr | input | 1 | Synchronous clear of requests and level memory |
| req_vec | output | NUM_PINS | Registered request bits |
| evt_vld | output | NUM_PINS | Per-pin event strobe, one cycle |
| evt_code | output | 2*NUM_PINS | Per-pin status code, two bits per pin |

## Verification
A wrong remembered level is visible at the ports within one cycle. It either produces an event the pin never made or drops one it did make, and it turns an edge into a missed or doubled request. A select bit stored without the fixed mask shows up the next time that pin falls while its request is pending: the request drops instead of holding. A wrong acknowledge decode clears the wrong pin or clears a level pin, which shows on `req_vec` one cycle after the strobe. The random phase compares every output on every cycle, so a wrong internal state shows at the ports either immediately or at the next transition of the pin it affects.

// File: rtl/irq_capture_pkg.sv
package irq_capture_pkg;

    typedef enum logic [1:0] {
        CAP_NONE      = 2'b00,
        CAP_MASKED    = 2'b01,
        CAP_COALESCED = 2'b10,
        CAP_NEW       = 2'b11
    } cap_code_e;

    typedef struct packed {
        logic      req;
        logic      lvl;
        logic      evt;
        cap_code_e code;
    } cap_pin_state_t;

endpackage

// File: rtl/irq_trig_sel_reg.sv
module irq_trig_sel_reg #(
    parameter int                    NUM_PINS = 8,
    parameter logic [NUM_PINS-1:0]   SEL_MASK = 8'hF8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_we,
    input  logic [NUM_PINS-1:0] sel_wdata,
    output logic [NUM_PINS-1:0] sel_mode
);

    logic [NUM_PINS-1:0] sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (sel_we) begin
            sel_d = sel_wdata & SEL_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel_mode = sel_q;

    p_sel_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel_we |=> sel_mode == ($past(sel_wdata) & SEL_MASK));

    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we |=> $stable(sel_mode));

endmodule

// File: rtl/irq_ack_decode.sv
module irq_ack_decode #(
    parameter int NUM_PINS = 8,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ack_vld,
    input  logic [IDX_W-1:0]    ack_idx,
    output logic [NUM_PINS-1:0] ack_hit
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_hit
        assign ack_hit[g] = ack_vld && (ack_idx == IDX_W'(g));
    end

    p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_hit));

    p_ack_present_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && (int'(ack_idx) < NUM_PINS)) |-> $countones(ack_hit) == 1);

endmodule

// File: rtl/irq_pin_cell.sv
module irq_pin_cell
    import irq_capture_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init_clr,
    input  logic       pin,
    input  logic       mask,
    input  logic       is_level,
    input  logic       ack_hit,
    output logic       req,
    output logic       evt,
    output logic [1:0] code
);

    cap_pin_state_t st_d, st_q;
    logic           changed;
    logic           rise;

    always_comb begin
        st_d      = st_q;
        st_d.evt  = 1'b0;
        st_d.code = CAP_NONE;
        changed   = (pin != st_q.lvl);
        rise      = pin && !st_q.lvl;
        if (init_clr) begin
            st_d.req = 1'b0;
            st_d.lvl = 1'b0;
        end else begin
            if (changed) begin
                st_d.evt = 1'b1;
                if (mask) begin
                    st_d.code = CAP_MASKED;
                end else if (pin && st_q.req) begin
                    st_d.code = CAP_COALESCED;
                end else begin
                    st_d.code = CAP_NEW;
                end
            end
            st_d.lvl = pin;
            if (is_level) begin
                st_d.req = pin;
            end else begin
                st_d.req = rise || (st_q.req && !ack_hit);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{req: 1'b0, lvl: 1'b0, evt: 1'b0, code: CAP_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign req  = st_q.req;
    assign evt  = st_q.evt;
    assign code = st_q.code;

    p_level_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_clr && is_level) |=> req == $past(pin));

    p_edge_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_clr && !is_level && pin && !st_q.lvl) |=> req);

    p_edge_low_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_clr && !is_level && !pin && !ack_hit) |=> req == $past(req));

    p_code_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt == (code != 2'b00));

    p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_clr && !is_level && ack_hit && !(pin && !st_q.lvl)) |=> !req);

    p_ack_vs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_clr && !is_level && ack_hit && pin && !st_q.lvl) |=> req);

    p_init_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> (!req && !evt && !st_q.lvl));

    p_event_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_clr && pin == st_q.lvl) |=> !evt);

endmodule

// File: rtl/irq_capture_reg.sv
module irq_capture_reg #(
    parameter int                  NUM_PINS = 8,
    parameter logic [NUM_PINS-1:0] SEL_MASK = 8'hF8,
    localparam int                 IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
    localparam int                 CODE_W   = 2 * NUM_PINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_lvl,
    input  logic [NUM_PINS-1:0] pin_mask,
    input  logic                ack_vld,
    input  logic [IDX_W-1:0]    ack_idx,
    input  logic                sel_we,
    input  logic [NUM_PINS-1:0] sel_wdata,
    input  logic                init_clr,
    output logic [NUM_PINS-1:0] req_vec,
    output logic [NUM_PINS-1:0] evt_vld,
    output logic [CODE_W-1:0]   evt_code
);

    logic [NUM_PINS-1:0] sel_mode;
    logic [NUM_PINS-1:0] ack_hit;

    irq_trig_sel_reg #(
        .NUM_PINS (NUM_PINS),
        .SEL_MASK (SEL_MASK)
    ) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .sel_mode  (sel_mode)
    );

    irq_ack_decode #(
        .NUM_PINS (NUM_PINS),
        .IDX_W    (IDX_W)
    ) u_ack (
        .clk     (clk),
        .rst_n   (rst_n),
        .ack_vld (ack_vld),
        .ack_idx (ack_idx),
        .ack_hit (ack_hit)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        irq_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .init_clr (init_clr),
            .pin      (pin_lvl[g]),
            .mask     (pin_mask[g]),
            .is_level (sel_mode[g]),
            .ack_hit  (ack_hit[g]),
            .req      (req_vec[g]),
            .evt      (evt_vld[g]),
            .code     (evt_code[2*g +: 2])
        );
    end

    p_no_stray_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_mode & ~SEL_MASK) == '0);

    p_reset_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_vec == '0 && evt_vld == '0));

endmodule

// File: tb/irq_capture_reg_bench.sv
module irq_capture_reg_bench;

    localparam int   CLK_PERIOD = 10;
    localparam int   N          = 8;
    localparam logic [N-1:0] SMASK = 8'hF8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   pin_lvl = '0;
    logic [N-1:0]   pin_mask = '0;
    logic           ack_vld = 1'b0;
    logic [2:0]     ack_idx = '0;
    logic           sel_we = 1'b0;
    logic [N-1:0]   sel_wdata = '0;
    logic           init_clr = 1'b0;
    logic [N-1:0]   req_vec;
    logic [N-1:0]   evt_vld;
    logic [2*N-1:0] evt_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [N-1:0]   m_req, m_lvl, m_sel, m_evt;
    logic [2*N-1:0] m_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_capture_reg u_irq_capture_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (pin_lvl),
        .pin_mask  (pin_mask),
        .ack_vld   (ack_vld),
        .ack_idx   (ack_idx),
        .sel_we    (sel_we),
        .sel_wdata (sel_wdata),
        .init_clr  (init_clr),
        .req_vec   (req_vec),
        .evt_vld   (evt_vld),
        .evt_code  (evt_code)
    );

    function automatic logic [1:0] status_of(logic p, logic msk, logic old_req);
        if (msk) return 2'b01;
        if (p && old_req) return 2'b10;
        return 2'b11;
    endfunction

    task automatic model_edge();
        logic [N-1:0]   nreq, nlvl, nevt;
        logic [2*N-1:0] ncode;
        nreq = m_req; nlvl = m_lvl; nevt = '0; ncode = '0;
        for (int i = 0; i < N; i++) begin
            if (init_clr) begin
                nreq[i] = 1'b0;
                nlvl[i] = 1'b0;
            end else begin
                if (pin_lvl[i] != m_lvl[i]) begin
                    nevt[i] = 1'b1;
                    ncode[2*i +: 2] = status_of(pin_lvl[i], pin_mask[i], m_req[i]);
                end
                nlvl[i] = pin_lvl[i];
                if (m_sel[i]) nreq[i] = pin_lvl[i];
                else nreq[i] = (pin_lvl[i] && !m_lvl[i]) ||
                               (m_req[i] && !(ack_vld && int'(ack_idx) == i));
            end
        end
        if (sel_we) m_sel = sel_wdata & SMASK;
        m_req = nreq; m_lvl = nlvl; m_evt = nevt; m_code = ncode;
    endtask

    task automatic check_outputs(string tag);
        checks++;
        if (req_vec !== m_req) begin
            failures++;
            $display("FAIL %s req_vec actual=%h expected=%h", tag, req_vec, m_req);
        end
        checks++;
        if (evt_vld !== m_evt) begin
            failures++;
            $display("FAIL %s evt_vld actual=%h expected=%h", tag, evt_vld, m_evt);
        end
        checks++;
        if (evt_code !== m_code) begin
            failures++;
            $display("FAIL %s evt_code actual=%h expected=%h", tag, evt_code, m_code);
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_outputs(tag);
        ack_vld = 1'b0;
        sel_we = 1'b0;
        init_clr = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_req = '0; m_lvl = '0; m_sel = '0; m_evt = '0; m_code = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_outputs("R10 reset state");

        // R2 / R4: rising edge on pin 0, unmasked -> new
        pin_lvl[0] = 1'b1; step("R2 rise new");
        step("R2 held high");
        // R3: falling edge keeps request, event code new
        pin_lvl[0] = 1'b0; step("R3 low keeps request");
        // R4: rise while pending -> coalesced
        pin_lvl[0] = 1'b1; step("R4 coalesced");
        // R4: masked pin still captures
        pin_mask[1] = 1'b1; pin_lvl[1] = 1'b1; step("R4 masked");
        pin_mask = '0;
        // R5: ack edge pin 0 while high
        ack_vld = 1'b1; ack_idx = 3'd0; step("R5 ack edge clears");
        // R7: write all ones, only masked bits take
        sel_wdata = 8'hFF; sel_we = 1'b1; step("R7 select write");
        // R1: level pin 3 follows
        pin_lvl[3] = 1'b1; step("R1 level high");
        ack_vld = 1'b1; ack_idx = 3'd3; step("R1 ack ignored on level");
        pin_lvl[3] = 1'b0; step("R1 level low clears");
        // R7: pin 2 stays edge despite write
        pin_lvl[2] = 1'b1; step("R7 pin2 edge rise");
        pin_lvl[2] = 1'b0; step("R7 pin2 edge holds");
        // R6: ack and rise same cycle on pin 0
        pin_lvl[0] = 1'b0; ack_vld = 1'b1; ack_idx = 3'd0; step("R6 prep");
        pin_lvl[0] = 1'b1; ack_vld = 1'b1; ack_idx = 3'd0; step("R6 edge beats ack");
        // R8: init with pins high, then re-capture
        pin_lvl = 8'hFF; step("R8 pins high");
        init_clr = 1'b1; step("R8 init clears");
        step("R8 recapture after init");
        // R7: back to edge mode
        sel_wdata = 8'h00; sel_we = 1'b1; pin_lvl = '0; step("R7 select cleared");

        // R9: random traffic, every output every cycle
        for (int k = 0; k < 600; k++) begin
            pin_lvl  = N'($urandom);
            pin_mask = N'($urandom);
            ack_vld  = ($urandom % 3) == 0;
            ack_idx  = 3'($urandom);
            sel_we   = ($urandom % 16) == 0;
            sel_wdata = N'($urandom);
            init_clr = ($urandom % 40) == 0;
            step("R9 random");
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule